// File: doc/BRIEF.md
# Programmable-Feedback Signature Compactor with Pass/Fail Verdict

This block is the response-analysis end of a logic self-test arrangement. While a test runs it folds one parallel response word from the circuit under test into a multiple-input signature register on every clock. Its feedback taps are a run-time coefficient vector. After a programmed number of compaction steps it compares the final signature with a supplied golden value and reduces the outcome to one good/bad flag.

A test starts on a rising edge of the test-enable input. The signature clears, a step counter loads the programmed length, and the register absorbs exactly that many response words. One cycle later the done flag rises and the verdict is latched. Both stay put until test-enable falls. Lowering test-enable during a run abandons the run.

Top module: `misr_sig_checker`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted and after its release with test_en low, done = 0, pass = 0 and signature = 0.
- R2: The first rising edge of clk at which test_en is sampled 1 after it was sampled 0 (the start edge) clears signature to all zeros and loads test_len, discarding any earlier signature.
- R3: On each compaction edge the register moves from s to n with n[0] = r[0] ^ (c[0] & s[W-1]) and n[i] = s[i-1] ^ r[i] ^ (c[i] & s[W-1]) for 0 < i < W, where W = SIG_W, r = resp_in and c = poly_coef sampled at that edge.
- R4: Exactly test_len compaction edges follow the start edge, and they consume the resp_in values present at those edges. The next edge raises done, so done is first high after the (test_len + 1)-th edge following the start edge.
- R5: When done rises, pass equals 1 exactly if the final signature equals golden_sig as sampled on that edge. pass is never 1 while done is 0.
- R6: While test_en stays 1 after done has risen, done, pass and signature hold their values whatever resp_in, poly_coef or golden_sig do.
- R7: One edge after test_en is sampled 0, done and pass are 0 and signature keeps its value. A run abandoned this way never raises done.
- R8: When RESP_W < SIG_W, stage positions RESP_W and above take no response bit. With poly_coef = 0, a length of 1 and resp_in all ones, the signature is 2^RESP_W - 1.
- R9: A test_len of 0 performs no compaction. done rises on the edge after the start edge, and pass = 1 exactly if golden_sig is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_en | input | 1 | Test mode; a rising edge starts a test, low ends or abandons it |
| resp_in | input | RESP_W | Response word from the circuit under test, one per cycle |
| poly_coef | input | SIG_W | Feedback coefficient per stage |
| golden_sig | input | SIG_W | Expected final signature |
| test_len | input | CNT_W | Number of compaction steps |
| done | output | 1 | Test finished, held until test_en falls |
| pass | output | 1 | Final signature matched golden value |
| signature | output | SIG_W | Current signature register |

## Verification
The bench builds the block with SIG_W = 8, RESP_W = 6 and CNT_W = 8. An 8-bit register keeps every expected signature easy to compute by hand. The narrower response word exercises the tied-off upper stages (R8) against a bit-level model. Lengths from 0 to 20 cover the zero-count shortcut, single-step runs and runs long enough that the feedback from the top stage toggles many times. A scoreboard checks each finishing signature and its latency.

// File: rtl/misr_chk_pkg.sv
package misr_chk_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RUN  = 2'd1,
      PH_DONE = 2'd2
   } misr_phase_t;

endpackage

// File: rtl/misr_stage_net.sv
module misr_stage_net #(
   parameter int SIG_W  = 16,
   parameter int RESP_W = 16
) (
   input  logic [SIG_W-1:0]  cur_sig,
   input  logic [RESP_W-1:0] resp_word,
   input  logic [SIG_W-1:0]  coef,
   output logic [SIG_W-1:0]  nxt_sig
);

   localparam int TOP = SIG_W - 1;

   logic [SIG_W-1:0] resp_ext;
   logic             fb_bit;

   assign fb_bit = cur_sig[TOP];

   // Response fan-in: stages beyond the response width get a zero input.
   for (genvar gi = 0; gi < SIG_W; gi++) begin : g_resp
      if (gi < RESP_W) begin : g_live
         assign resp_ext[gi] = resp_word[gi];
      end else begin : g_tied
         assign resp_ext[gi] = 1'b0;
      end
   end

   // One XOR stage per flop, with a coefficient-gated feedback term.
   for (genvar gs = 0; gs < SIG_W; gs++) begin : g_stage
      if (gs == 0) begin : g_head
         assign nxt_sig[gs] = resp_ext[gs] ^ (coef[gs] & fb_bit);
      end else begin : g_body
         assign nxt_sig[gs] = cur_sig[gs-1] ^ resp_ext[gs] ^ (coef[gs] & fb_bit);
      end
   end

endmodule

// File: rtl/misr_sig_reg.sv
module misr_sig_reg #(
   parameter int SIG_W  = 16,
   parameter int RESP_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   input  logic [SIG_W-1:0]  coef,
   input  logic [RESP_W-1:0] resp_word,
   output logic [SIG_W-1:0]  sig
);

   logic [SIG_W-1:0] sig_nxt;

   misr_stage_net #(
      .SIG_W  (SIG_W),
      .RESP_W (RESP_W)
   ) u_net (
      .cur_sig   (sig),
      .resp_word (resp_word),
      .coef      (coef),
      .nxt_sig   (sig_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig <= '0;
      end else if (clear) begin
         sig <= '0;
      end else if (step) begin
         sig <= sig_nxt;
      end
   end

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (sig == '0)) else $error("signature not cleared on start"); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !step) |=> $stable(sig)) else $error("signature moved without step"); // R6

endmodule

// File: rtl/misr_run_ctrl.sv
module misr_run_ctrl
   import misr_chk_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             test_en,
   input  logic [CNT_W-1:0] test_len,
   output logic             start,
   output logic             step,
   output logic             finish,
   output misr_phase_t      phase
);

   logic             en_q;
   logic [CNT_W-1:0] left_cnt;
   logic             cnt_zero;

   assign cnt_zero = (left_cnt == '0);
   assign start    = test_en && !en_q;
   assign step     = test_en && (phase == PH_RUN) && !cnt_zero;
   assign finish   = test_en && (phase == PH_RUN) && cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else begin
         en_q <= test_en;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         left_cnt <= '0;
      end else if (!test_en) begin
         phase    <= PH_IDLE;
      end else if (start) begin
         phase    <= PH_RUN;
         left_cnt <= test_len;
      end else if (step) begin
         left_cnt <= left_cnt - 1'b1;
      end else if (finish) begin
         phase    <= PH_DONE;
      end
   end

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RUN && test_en && cnt_zero) |=> (phase == PH_DONE))
      else $error("run phase outlived its count"); // R4

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DONE && test_en) |=> (phase == PH_DONE))
      else $error("done phase left while enabled"); // R6

endmodule

// File: rtl/misr_verdict.sv
module misr_verdict #(
   parameter int SIG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             test_en,
   input  logic             finish,
   input  logic [SIG_W-1:0] sig,
   input  logic [SIG_W-1:0] golden,
   output logic             pass
);

   logic match;

   assign match = (sig == golden);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pass <= 1'b0;
      end else if (!test_en) begin
         pass <= 1'b0;
      end else if (finish) begin
         pass <= match;
      end
   end

endmodule

// File: rtl/misr_sig_checker.sv
module misr_sig_checker
   import misr_chk_pkg::*;
#(
   parameter int SIG_W  = 16,
   parameter int RESP_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_en,
   input  logic [RESP_W-1:0] resp_in,
   input  logic [SIG_W-1:0]  poly_coef,
   input  logic [SIG_W-1:0]  golden_sig,
   input  logic [CNT_W-1:0]  test_len,
   output logic              done,
   output logic              pass,
   output logic [SIG_W-1:0]  signature
);

   if (SIG_W < 2) begin : g_bad_sig
      $error("SIG_W must be at least 2");
   end
   if (RESP_W < 1 || RESP_W > SIG_W) begin : g_bad_resp
      $error("RESP_W must be in 1..SIG_W");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic        start_w;
   logic        step_w;
   logic        finish_w;
   misr_phase_t phase_w;

   misr_run_ctrl #(
      .CNT_W (CNT_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .test_en  (test_en),
      .test_len (test_len),
      .start    (start_w),
      .step     (step_w),
      .finish   (finish_w),
      .phase    (phase_w)
   );

   misr_sig_reg #(
      .SIG_W  (SIG_W),
      .RESP_W (RESP_W)
   ) u_sig (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (start_w),
      .step      (step_w),
      .coef      (poly_coef),
      .resp_word (resp_in),
      .sig       (signature)
   );

   misr_verdict #(
      .SIG_W (SIG_W)
   ) u_verdict (
      .clk     (clk),
      .rst_n   (rst_n),
      .test_en (test_en),
      .finish  (finish_w),
      .sig     (signature),
      .golden  (golden_sig),
      .pass    (pass)
   );

   assign done = (phase_w == PH_DONE);

   AST_DONE_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(test_en)) else $error("done rose without test mode"); // R4

   AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      pass |-> done) else $error("pass without done"); // R5

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done)) |-> ($stable(signature) && $stable(pass)))
      else $error("result moved while done"); // R6

   AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(test_en) |-> (!done && !pass)) else $error("flags survived test_en low"); // R7

endmodule

// File: tb/misr_sig_checker_tb.sv
module misr_sig_checker_tb;

   localparam int SW = 8;
   localparam int RW = 6;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          test_en = 1'b0;
   logic [RW-1:0] resp_in = '0;
   logic [SW-1:0] poly_coef = '0;
   logic [SW-1:0] golden_sig = '0;
   logic [CW-1:0] test_len = '0;
   logic          done;
   logic          pass;
   logic [SW-1:0] signature;

   int unsigned n_run = 0;
   int unsigned n_fail = 0;
   int unsigned cyc = 0;
   bit          ended = 0;

   typedef struct {
      logic [SW-1:0] sig;
      logic          pas;
      int unsigned   start_cyc;
      int unsigned   len;
   } exp_t;

   exp_t sb_q[$];

   misr_sig_checker #(.SIG_W(SW), .RESP_W(RW), .CNT_W(CW)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .test_en    (test_en),
      .resp_in    (resp_in),
      .poly_coef  (poly_coef),
      .golden_sig (golden_sig),
      .test_len   (test_len),
      .done       (done),
      .pass       (pass),
      .signature  (signature)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int unsigned act, input int unsigned exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [SW-1:0] step_model(input logic [SW-1:0] s, input logic [RW-1:0] r,
                                                input logic [SW-1:0] c);
      logic [SW-1:0] n;
      logic [SW-1:0] rx;
      rx = SW'(r);
      for (int i = 0; i < SW; i++) begin
         n[i] = rx[i] ^ (c[i] & s[SW-1]) ^ ((i == 0) ? 1'b0 : s[(i == 0) ? 0 : i-1]);
      end
      return n;
   endfunction

   function automatic logic [RW-1:0] resp_of(input int k, input int seed, input int base);
      return RW'(k * seed + base);
   endfunction

   task automatic finish_up();
      if (!ended) begin
         ended = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   // Monitor: pops an expected item whenever done rises.
   logic done_q = 1'b0;
   always @(negedge clk) begin
      if (rst_n && done && !done_q) begin
         if (sb_q.size() == 0) begin
            check(0, "R7 unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(signature == e.sig, "R3 final signature", signature, e.sig);
            check(pass == e.pas, "R5 verdict", pass, e.pas);
            check(cyc - e.start_cyc == e.len + 1, "R4 latency", cyc - e.start_cyc, e.len + 1);
         end
      end
      done_q <= done;
   end

   // Driver: runs one full test, pushes the expected result, checks hold and release.
   task automatic run_test(input int len, input logic [SW-1:0] poly, input int seed,
                           input int base, input logic [SW-1:0] gx);
      logic [SW-1:0] s;
      exp_t          e;
      s = '0;
      for (int k = 0; k < len; k++) s = step_model(s, resp_of(k, seed, base), poly);
      @(negedge clk);
      poly_coef  = poly;
      golden_sig = s ^ gx;
      test_len   = CW'(len);
      test_en    = 1'b1;
      e.sig = s; e.pas = (gx == '0); e.start_cyc = cyc + 1; e.len = len;
      sb_q.push_back(e);
      @(negedge clk);
      check(signature == '0, "R2 cleared at start", signature, 0);
      for (int k = 0; k < len; k++) begin
         if (k != 0) @(negedge clk);
         resp_in = resp_of(k, seed, base);
      end
      while (!done) @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         golden_sig = ~golden_sig;
         resp_in    = resp_in + 6'd13;
         poly_coef  = ~poly_coef;
      end
      @(negedge clk);
      check(done == 1'b1, "R6 done held", done, 1);
      check(pass == e.pas, "R6 pass held", pass, e.pas);
      check(signature == s, "R6 signature held", signature, s);
      test_en = 1'b0;
      @(negedge clk);
      check(done == 1'b0 && pass == 1'b0, "R7 flags cleared", {done, pass}, 0);
      check(signature == s, "R7 signature kept", signature, s);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(0, "watchdog", 0, 1);
      finish_up();
   end

   initial begin
      #5;
      check(done == 0 && pass == 0 && signature == 0, "R1 in reset", {done, pass, signature}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(done == 0 && pass == 0 && signature == 0, "R1 after release", {done, pass, signature}, 0);

      run_test(5, 8'hB8, 7, 3, 8'h00);    // R3 matching golden
      run_test(7, 8'h1D, 11, 5, 8'h01);   // R5 mismatch by one bit
      run_test(0, 8'hFF, 3, 1, 8'h00);    // R9 zero count, golden 0
      run_test(0, 8'hFF, 3, 1, 8'h01);    // R9 zero count, golden nonzero
      run_test(1, 8'h00, 0, 63, 8'h00);   // R8 all-ones response, tied stages
      check(signature == 8'h3F, "R8 upper stages tied", signature, 8'h3F);

      // R7 abandoned run: start, feed a few words, drop test mode.
      @(negedge clk);
      poly_coef = 8'h8E; test_len = 8'd10; test_en = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         resp_in = resp_of(k, 9, 2);
      end
      test_en = 1'b0;
      for (int k = 0; k < 14; k++) begin
         @(negedge clk);
         if (done) check(0, "R7 abandoned run raised done", 1, 0);
      end
      check(done == 0, "R7 abandoned run stays idle", done, 0);

      run_test(20, 8'h8E, 37, 5, 8'h00);  // R2 clear after abandoned run, R3 long run
      run_test(12, 8'hC3, 21, 9, 8'h80);  // R5 mismatch in top bit

      repeat (3) @(negedge clk);
      check(sb_q.size() == 0, "R4 every test finished", sb_q.size(), 0);
      finish_up();
   end

endmodule